// File: doc/BRIEF.md
# Vectored Interrupt Redirection Controller

This block turns level interrupt lines from expansion slots into message writes aimed at a processor. Each of its four interrupt inputs has a pair of 32-bit words in a 32-word redirection table. The first word of the pair holds the vector, the mask and the trigger and polarity flags. The second word holds the destination in a swizzled form. Software does not address the table directly. It writes a word index into a select register and then reads or writes the chosen word through a data window. To acknowledge an interrupt, software writes the vector number to an end-of-interrupt register.

When an enabled input goes from idle to asserted, the block marks that input pending. If the input was not already pending, it queues one 32-bit message write. The message carries the vector and goes to the unswizzled destination, with ones in the upper address half. Messages leave one at a time through a valid/ready request port. Bus arbitration for that write takes place outside the block.

Top module: `vint_redir`

## Requirements
- R1: After reset, select reads 0. Table word 16+2i reads 0x0001A000|(i+2): bit 16 masked, bit 15 level, bit 13 active-low, vector i+2. Word 17+2i reads 0xA0FF0000, the swizzled form of 0xFFFA0000. Every other word reads 0. No input is pending and msg_valid is low.
- R2: Offset 0x800 is the 32-bit select register and can be read and written. Offset 0x810 reads and writes table word [select] when select is below 32. Read data appears on reg_rdata in the cycle after the read strobe. Every bit of a table word is stored exactly as written, including bit 15 (trigger), bit 13 (polarity) and bit 8 (lowest-priority mode), none of which changes delivery. Unmapped offsets read 0.
- R3: A window read while select equals 1 returns the version word 0x00200001. Its upper 16 bits hold the table size, 32.
- R4: A window write with select of 32 or more changes no table word. A window read with such a select returns 0.
- R5: An input is enabled when its first word has bit 16 clear and its second word is nonzero. When an enabled input becomes asserted, it becomes pending. If it was not pending before, exactly one message is issued. The message data is the vector (bits 5:0), zero-extended. The message address is {32'hFFFFFFFF, ((d<<4)&0x0FF00000)|((d>>12)&0x000FF000)|0xF0000000}, where d is the second word.
- R6: Asserting a masked input, or an input whose second word is zero, sets no pending bit and issues no message.
- R7: An input that stays asserted produces exactly one message. A later end-of-interrupt write does not produce another one.
- R8: Deasserting an input clears its pending bit. The next assertion of that input issues a new message.
- R9: Writing value v to offset 0x840 clears the pending bit of every input whose vector equals v. It leaves the other inputs unchanged.
- R10: Slot line s drives input s mod 4. An input is asserted while any of its slot lines is high.
- R11: Only one message is offered at a time. While msg_ready is low, msg_valid, msg_addr and msg_data hold steady. Messages raised in the same cycle leave in ascending input order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| slot_irq | input | 8 | Level interrupt lines from slots |
| irq_pending | output | 4 | Pending bit per input |
| msg_valid | output | 1 | Message write request |
| msg_ready | input | 1 | Message accepted by the bus side |
| msg_addr | output | 64 | Message destination address |
| msg_data | output | 32 | Message data (vector) |

## Verification
The bench checks for an input held high after end-of-interrupt. A level-retriggering design would send a second message there. It also checks two inputs that share a vector. If end-of-interrupt matched on the input number, it would clear the wrong pending bit, or only one of the two. Window accesses with select 1 and with select of 32 or more are checked too. A design that aliased the index would overwrite a low table word, and one that ignored the version case would return stored data. Finally, the bench stalls msg_ready while three inputs rise together. A design without arbitration would lose messages, change them during the stall, or send them out of order.

// File: rtl/vint_redir_pkg.sv
`timescale 1ns/1ps
package vint_redir_pkg;
  localparam int unsigned VEC_W    = 6;
  localparam int unsigned MASK_BIT = 16;
  localparam int unsigned TRIG_BIT = 15;
  localparam int unsigned POL_BIT  = 13;
  localparam int unsigned LO_BASE  = 16;     // word of input 0 low entry
  localparam int unsigned OFS_SEL  = 'h800;
  localparam int unsigned OFS_WIN  = 'h810;
  localparam int unsigned OFS_EOI  = 'h840;

  // stored destination word -> 32-bit target address
  function automatic logic [31:0] dest_unswizzle(input logic [31:0] d);
    return ((d << 4) & 32'h0FF0_0000) | ((d >> 12) & 32'h000F_F000) | 32'hF000_0000;
  endfunction

  // target address -> stored destination word
  function automatic logic [31:0] dest_swizzle(input logic [31:0] a);
    return ((a & 32'h0FF0_0000) >> 4) | ((a & 32'h000F_F000) << 12);
  endfunction
endpackage

// File: rtl/vint_redir_regs.sv
`timescale 1ns/1ps
module vint_redir_regs
  import vint_redir_pkg::*;
#(
  parameter int unsigned N_IN      = 4,
  parameter int unsigned TBL_WORDS = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned VEC_BASE  = 2,
  parameter logic [31:0] DEF_CPU   = 32'hFFFA_0000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  output logic                         eoi_stb,
  output logic [31:0]                  eoi_val,
  output logic [N_IN-1:0]              ent_live,
  output logic [N_IN-1:0][VEC_W-1:0]   ent_vec,
  output logic [N_IN-1:0][63:0]        ent_route
);
  localparam int unsigned IDX_W = $clog2(TBL_WORDS);
  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(OFS_SEL);
  localparam logic [ADDR_W-1:0] A_WIN = ADDR_W'(OFS_WIN);
  localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(OFS_EOI);
  localparam logic [31:0] VERSION = (32'(TBL_WORDS) << 16) | 32'd1;

  function automatic logic [31:0] rst_word(input int unsigned k);
    if (k >= LO_BASE && k < LO_BASE + 2 * N_IN) begin
      if (((k - LO_BASE) % 2) == 0)
        return (32'd1 << MASK_BIT) | (32'd1 << TRIG_BIT) | (32'd1 << POL_BIT) |
               32'((k - LO_BASE) / 2 + VEC_BASE);
      else
        return dest_swizzle(DEF_CPU);
    end
    return 32'd0;
  endfunction

  logic [TBL_WORDS-1:0][31:0] tbl_q;
  logic [31:0]                sel_q;
  logic [31:0]                rdata_q, rdata_n;
  logic                       sel_we, win_we, sel_ok;
  logic [IDX_W-1:0]           idx;

  // decode
  always_comb begin
    sel_ok  = sel_q < 32'(TBL_WORDS);
    idx     = sel_q[IDX_W-1:0];
    sel_we  = reg_wr && (reg_addr == A_SEL);
    win_we  = reg_wr && (reg_addr == A_WIN) && sel_ok;
    eoi_stb = reg_wr && (reg_addr == A_EOI);
    eoi_val = reg_wdata;
  end

  // read mux
  always_comb begin
    rdata_n = 32'd0;
    if (reg_addr == A_SEL) begin
      rdata_n = sel_q;
    end else if (reg_addr == A_WIN) begin
      if (sel_q == 32'd1)  rdata_n = VERSION;
      else if (sel_ok)     rdata_n = tbl_q[idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 32'd0;
      rdata_q <= 32'd0;
      for (int w = 0; w < TBL_WORDS; w++) tbl_q[w] <= rst_word(w);
    end else begin
      if (sel_we) sel_q   <= reg_wdata;
      if (reg_rd) rdata_q <= rdata_n;
      if (win_we) tbl_q[idx] <= reg_wdata;
    end
  end

  assign reg_rdata = rdata_q;

  // per-input decoded entry view
  for (genvar i = 0; i < N_IN; i++) begin : g_ent
    localparam int unsigned LW = LO_BASE + 2 * i;
    assign ent_vec[i]   = tbl_q[LW][VEC_W-1:0];
    assign ent_live[i]  = !tbl_q[LW][MASK_BIT] && (tbl_q[LW+1] != 32'd0);
    assign ent_route[i] = {32'hFFFF_FFFF, dest_unswizzle(tbl_q[LW+1])};
  end
endmodule

// File: rtl/vint_redir_pend.sv
`timescale 1ns/1ps
module vint_redir_pend
  import vint_redir_pkg::*;
#(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_SLOT = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_SLOT-1:0]          slot_irq,
  input  logic [N_IN-1:0]            ent_live,
  input  logic [N_IN-1:0][VEC_W-1:0] ent_vec,
  input  logic                       eoi_stb,
  input  logic [31:0]                eoi_val,
  input  logic [N_IN-1:0]            grant,
  output logic [N_IN-1:0]            pending,
  output logic [N_IN-1:0]            req
);
  function automatic logic [N_SLOT-1:0] slot_mask(input int unsigned inp);
    logic [N_SLOT-1:0] m;
    m = '0;
    for (int s = 0; s < N_SLOT; s++) if ((s % N_IN) == inp) m[s] = 1'b1;
    return m;
  endfunction

  logic [N_IN-1:0] lvl, lvl_q, pend_q, pend_n, req_q, req_n;
  logic [N_IN-1:0] rise, fall, eoi_hit;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    localparam logic [N_SLOT-1:0] SMASK = slot_mask(i);
    assign lvl[i]     = |(slot_irq & SMASK);
    assign rise[i]    = lvl[i] && !lvl_q[i];
    assign fall[i]    = !lvl[i] && lvl_q[i];
    assign eoi_hit[i] = eoi_stb && (eoi_val == 32'(ent_vec[i]));
  end

  always_comb begin
    pend_n = pend_q;
    req_n  = req_q;
    for (int i = 0; i < N_IN; i++) begin
      if (rise[i] && ent_live[i])  pend_n[i] = 1'b1;
      else if (fall[i])            pend_n[i] = 1'b0;
      else if (eoi_hit[i])         pend_n[i] = 1'b0;
      if (rise[i] && ent_live[i] && !pend_q[i]) req_n[i] = 1'b1;
      else if (grant[i])                        req_n[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      pend_q <= '0;
      req_q  <= '0;
    end else begin
      lvl_q  <= lvl;
      pend_q <= pend_n;
      req_q  <= req_n;
    end
  end

  assign pending = pend_q;
  assign req     = req_q;
endmodule

// File: rtl/vint_redir_msgq.sv
`timescale 1ns/1ps
module vint_redir_msgq
  import vint_redir_pkg::*;
#(
  parameter int unsigned N_IN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_IN-1:0]            req,
  input  logic [N_IN-1:0][VEC_W-1:0] ent_vec,
  input  logic [N_IN-1:0][63:0]      ent_route,
  input  logic                       msg_ready,
  output logic [N_IN-1:0]            grant,
  output logic                       msg_valid,
  output logic [63:0]                msg_addr,
  output logic [31:0]                msg_data
);
  logic             valid_q, load, found;
  logic [63:0]      addr_q, addr_n;
  logic [31:0]      data_q, data_n;
  logic [N_IN-1:0]  pick;

  // lowest-numbered request wins
  always_comb begin
    found  = 1'b0;
    pick   = '0;
    addr_n = 64'd0;
    data_n = 32'd0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (req[i]) begin
        found  = 1'b1;
        pick   = '0;
        pick[i] = 1'b1;
        addr_n = ent_route[i];
        data_n = 32'(ent_vec[i]);
      end
    end
    load  = !valid_q || msg_ready;
    grant = (load && found) ? pick : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= 64'd0;
      data_q  <= 32'd0;
    end else if (load) begin
      valid_q <= found;
      addr_q  <= addr_n;
      data_q  <= data_n;
    end
  end

  assign msg_valid = valid_q;
  assign msg_addr  = addr_q;
  assign msg_data  = data_q;
endmodule

// File: rtl/vint_redir.sv
`timescale 1ns/1ps
module vint_redir
  import vint_redir_pkg::*;
#(
  parameter int unsigned N_IN      = 4,
  parameter int unsigned N_SLOT    = 8,
  parameter int unsigned TBL_WORDS = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned VEC_BASE  = 2,
  parameter logic [31:0] DEF_CPU   = 32'hFFFA_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [N_SLOT-1:0] slot_irq,
  output logic [N_IN-1:0]   irq_pending,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data
);
  logic [1:0]                 rst_sync_q;
  logic                       rst_sync_n;
  logic                       eoi_stb;
  logic [31:0]                eoi_val;
  logic [N_IN-1:0]            ent_live, req_w, grant_w;
  logic [N_IN-1:0][VEC_W-1:0] ent_vec;
  logic [N_IN-1:0][63:0]      ent_route;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  vint_redir_regs #(
    .N_IN(N_IN), .TBL_WORDS(TBL_WORDS), .ADDR_W(ADDR_W),
    .VEC_BASE(VEC_BASE), .DEF_CPU(DEF_CPU)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eoi_stb(eoi_stb), .eoi_val(eoi_val),
    .ent_live(ent_live), .ent_vec(ent_vec), .ent_route(ent_route)
  );

  vint_redir_pend #(.N_IN(N_IN), .N_SLOT(N_SLOT)) u_pend (
    .clk(clk), .rst_n(rst_sync_n), .slot_irq(slot_irq),
    .ent_live(ent_live), .ent_vec(ent_vec),
    .eoi_stb(eoi_stb), .eoi_val(eoi_val), .grant(grant_w),
    .pending(irq_pending), .req(req_w)
  );

  vint_redir_msgq #(.N_IN(N_IN)) u_msgq (
    .clk(clk), .rst_n(rst_sync_n), .req(req_w),
    .ent_vec(ent_vec), .ent_route(ent_route), .msg_ready(msg_ready),
    .grant(grant_w), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: rtl/vint_redir_chk.sv
`timescale 1ns/1ps
module vint_redir_chk
  import vint_redir_pkg::*;
#(
  parameter int unsigned N_IN      = 4,
  parameter int unsigned N_SLOT    = 8,
  parameter int unsigned TBL_WORDS = 32,
  parameter int unsigned ADDR_W    = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic [31:0]       sel,
  input logic [N_SLOT-1:0] slot_irq,
  input logic [N_IN-1:0]   pending,
  input logic [N_IN-1:0]   grant,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [63:0]       msg_addr,
  input logic [31:0]       msg_data
);
  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(OFS_SEL);
  localparam logic [ADDR_W-1:0] A_WIN = ADDR_W'(OFS_WIN);
  localparam logic [31:0] VERSION = (32'(TBL_WORDS) << 16) | 32'd1;

  // R11
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  // R11
  grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R8
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_irq == '0) |=> (pending == '0));

  // R3
  version_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_WIN && sel == 32'd1) |=> (reg_rdata == VERSION));

  // R2
  sel_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_SEL) |=> (reg_rdata == $past(sel)));

  // R5
  msg_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_data[31:VEC_W] == '0 && msg_addr[63:28] == '1));
endmodule

bind vint_redir vint_redir_chk #(
  .N_IN(N_IN), .N_SLOT(N_SLOT), .TBL_WORDS(TBL_WORDS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .sel(u_regs.sel_q), .slot_irq(slot_irq),
  .pending(irq_pending), .grant(grant_w), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/vint_redir_test.sv
`timescale 1ns/1ps
module vint_redir_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [7:0]  slot_irq;
  logic [3:0]  irq_pending;
  logic        msg_valid, msg_ready;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  always #2.5 clk = ~clk;

  vint_redir uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .slot_irq(slot_irq), .irq_pending(irq_pending), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int ready_mode = 1;   // 0 stall, 1 always, 2 random

  function automatic logic [31:0] swz(input logic [31:0] a);
    return ((a & 32'h0FF0_0000) >> 4) | ((a & 32'h000F_F000) << 12);
  endfunction
  function automatic logic [31:0] unswz(input logic [31:0] d);
    return ((d << 4) & 32'h0FF0_0000) | ((d >> 12) & 32'h000F_F000) | 32'hF000_0000;
  endfunction
  function automatic logic [95:0] exp_msg(input logic [31:0] lo, input logic [31:0] dst);
    return {32'hFFFF_FFFF, unswz(dst), 26'd0, lo[5:0]};
  endfunction
  function automatic logic [3:0] lvl_of(input logic [7:0] s);
    logic [3:0] r = '0;
    for (int j = 0; j < 8; j++) if (s[j]) r[j % 4] = 1'b1;
    return r;
  endfunction

  task automatic check(input string tag, input logic [95:0] got, input logic [95:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  // ready driver, away from the sampling edge
  always @(posedge clk) begin
    #1;
    case (ready_mode)
      0:       msg_ready = 1'b0;
      1:       msg_ready = 1'b1;
      default: msg_ready = 1'($urandom % 2);
    endcase
  end

  // message monitor
  logic [95:0] cap [256];
  int          cap_n = 0;
  logic        pv = 1'b0, pr = 1'b0;
  logic [95:0] pm = '0;
  always @(negedge clk) begin
    if (pv && !pr) begin
      check("R11 valid held in stall", {95'd0, msg_valid}, 96'd1);
      check("R11 message stable in stall", {msg_addr, msg_data}, pm);
    end
    if (msg_valid && msg_ready && cap_n < 256) begin
      cap[cap_n] = {msg_addr, msg_data};
      cap_n++;
    end
    pv = msg_valid; pr = msg_ready; pm = {msg_addr, msg_data};
  end

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask
  task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask
  task automatic win_write(input logic [31:0] s, input logic [31:0] d);
    reg_write(12'h800, s);
    reg_write(12'h810, d);
  endtask
  task automatic win_read(input logic [31:0] s, output logic [31:0] d);
    reg_write(12'h800, s);
    reg_read(12'h810, d);
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] lo [4];
    logic [31:0] dst [4];
    logic [3:0]  en, exppend;
    int base;
    void'($urandom(32'd7331));
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    slot_irq = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check("R1 pending at reset", {92'd0, irq_pending}, 96'd0);
    check("R1 no message at reset", {95'd0, msg_valid}, 96'd0);
    reg_read(12'h800, rd);
    check("R1 select at reset", {64'd0, rd}, 96'd0);
    for (int i = 0; i < 4; i++) begin
      win_read(32'(16 + 2 * i), rd);
      check("R1 low entry default", {64'd0, rd}, {64'd0, 32'h0001_A000 | 32'(i + 2)});
      win_read(32'(17 + 2 * i), rd);
      check("R1 destination default", {64'd0, rd}, {64'd0, 32'hA0FF_0000});
    end
    win_read(32'd8, rd);
    check("R1 other word zero", {64'd0, rd}, 96'd0);

    // R2 select and window
    win_write(32'd5, 32'h1234_5678);
    win_read(32'd5, rd);
    check("R2 window readback", {64'd0, rd}, {64'd0, 32'h1234_5678});
    reg_read(12'h800, rd);
    check("R2 select readback", {64'd0, rd}, {64'd0, 32'd5});
    reg_read(12'h020, rd);
    check("R2 unmapped offset", {64'd0, rd}, 96'd0);

    // R3 version word
    win_read(32'd1, rd);
    check("R3 version", {64'd0, rd}, {64'd0, 32'h0020_0001});

    // R4 out-of-range select
    win_write(32'd37, 32'hDEAD_BEEF);
    win_read(32'd37, rd);
    check("R4 out-of-range read", {64'd0, rd}, 96'd0);
    win_read(32'd5, rd);
    check("R4 no alias write", {64'd0, rd}, {64'd0, 32'h1234_5678});

    // R5 delivery on input 1
    ready_mode = 1;
    lo[1] = 32'h0000_A125; dst[1] = swz(32'hFFFA_4000);
    win_write(32'h12, lo[1]);
    win_write(32'h13, dst[1]);
    win_read(32'h12, rd);
    check("R2 flag bits stored", {64'd0, rd}, {64'd0, lo[1]});
    base = cap_n;
    slot_irq[1] = 1'b1;
    idle(12);
    check("R5 one message", 96'(cap_n - base), 96'd1);
    check("R5 message content", cap[base], exp_msg(lo[1], dst[1]));
    check("R5 pending set", {92'd0, irq_pending}, 96'b0010);

    // R9 / R7 end-of-interrupt with input held
    base = cap_n;
    reg_write(12'h840, 32'h25);
    check("R9 eoi clears pending", {92'd0, irq_pending}, 96'd0);
    idle(20);
    check("R7 no repeat while held", 96'(cap_n - base), 96'd0);

    // R8 deassert and reassert
    slot_irq[1] = 1'b0;
    idle(3);
    check("R8 pending after deassert", {92'd0, irq_pending}, 96'd0);
    base = cap_n;
    slot_irq[1] = 1'b1;
    idle(12);
    check("R8 new message", 96'(cap_n - base), 96'd1);
    check("R8 message content", cap[base], exp_msg(lo[1], dst[1]));
    slot_irq[1] = 1'b0;
    idle(3);

    // R6 masked input and zero destination
    base = cap_n;
    slot_irq[2] = 1'b1;
    idle(15);
    check("R6 masked silent", 96'(cap_n - base), 96'd0);
    check("R6 masked not pending", {92'd0, irq_pending}, 96'd0);
    slot_irq[2] = 1'b0;
    win_write(32'h17, 32'd0);
    win_write(32'h16, 32'h0000_0033);
    slot_irq[3] = 1'b1;
    idle(15);
    check("R6 zero destination silent", 96'(cap_n - base), 96'd0);
    check("R6 zero destination not pending", {92'd0, irq_pending}, 96'd0);
    slot_irq[3] = 1'b0;
    idle(3);

    // R10 slot 5 drives input 1
    base = cap_n;
    slot_irq[5] = 1'b1;
    idle(12);
    check("R10 slot mapping count", 96'(cap_n - base), 96'd1);
    check("R10 slot mapping content", cap[base], exp_msg(lo[1], dst[1]));
    slot_irq[5] = 1'b0;
    idle(3);

    // R11 ordering under stall, R9 shared vector
    lo[0] = 32'h0000_0030; dst[0] = swz(32'hFFFA_8000);
    lo[2] = 32'h0000_2030; dst[2] = swz(32'hFFFA_C000);
    win_write(32'h10, lo[0]); win_write(32'h11, dst[0]);
    win_write(32'h14, lo[2]); win_write(32'h15, dst[2]);
    ready_mode = 0;
    idle(2);
    base = cap_n;
    slot_irq = 8'b0000_0111;
    idle(12);
    check("R11 nothing taken in stall", 96'(cap_n - base), 96'd0);
    ready_mode = 1;
    idle(12);
    check("R11 three messages", 96'(cap_n - base), 96'd3);
    check("R11 first is input 0", cap[base], exp_msg(lo[0], dst[0]));
    check("R11 second is input 1", cap[base + 1], exp_msg(lo[1], dst[1]));
    check("R11 third is input 2", cap[base + 2], exp_msg(lo[2], dst[2]));
    check("R9 all pending", {92'd0, irq_pending}, 96'b0111);
    reg_write(12'h840, 32'h30);
    check("R9 shared vector cleared", {92'd0, irq_pending}, 96'b0010);
    slot_irq = '0;
    idle(4);

    // random phase: R5, R6, R8, R10 against bench model
    for (int i = 0; i < 4; i++) begin
      logic masked, dzero;
      masked = (($urandom % 4) == 0);
      dzero  = (($urandom % 5) == 0);
      lo[i]  = 32'h0000_A000 | ($urandom % 64) | (masked ? 32'h0001_0000 : 32'd0);
      dst[i] = dzero ? 32'd0 : swz(32'hF000_1000 | ($urandom & 32'h0FFF_F000));
      en[i]  = !masked && !dzero;
      win_write(32'(16 + 2 * i), lo[i]);
      win_write(32'(17 + 2 * i), dst[i]);
    end
    exppend = '0;
    ready_mode = 2;
    for (int it = 0; it < 80; it++) begin
      logic [7:0] nsl;
      logic [3:0] o, nw;
      int s, exp_cnt, ei;
      s = int'($urandom % 8);
      nsl = slot_irq;
      nsl[s] = 1'($urandom % 2);
      o = lvl_of(slot_irq);
      nw = lvl_of(nsl);
      exp_cnt = 0; ei = 0;
      for (int i = 0; i < 4; i++) begin
        if (nw[i] && !o[i]) begin
          if (en[i]) begin exppend[i] = 1'b1; exp_cnt = 1; ei = i; end
        end else if (!nw[i] && o[i]) begin
          exppend[i] = 1'b0;
        end
      end
      base = cap_n;
      slot_irq = nsl;
      idle(30);
      check("R5/R6/R10 random message count", 96'(cap_n - base), 96'(exp_cnt));
      if (exp_cnt == 1 && cap_n > base)
        check("R5 random message content", cap[base], exp_msg(lo[ei], dst[ei]));
      check("R8 random pending", {92'd0, irq_pending}, {92'd0, exppend});
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule